// File: doc/BRIEF.md
# Directory coherence state controller

This block is the home node for a small group of memory blocks shared by a fixed set of caches. For every block it keeps a directory entry made of a block state (uncached, shared or exclusive) and a presence vector with one bit per cache. Caches send read misses, write misses and upgrade requests (a write to a block the cache already holds shared and clean) through a single request port. The controller handles one request at a time. It reads the entry, works out the new state and presence vector, and sends invalidate or fetch messages point to point. Messages go only to caches whose presence bit is set, and never to all caches.

After every targeted cache has acknowledged, the controller sends one reply to the requester. The reply carries the block data and a flag that says whether the requester now holds the block exclusively. When a block is fetched from an exclusive owner, the owner's data is written back to memory and forwarded to the requester in the same cycle. Memory is a simple read port with combinational data plus a write strobe. The directory sits in a single-port-per-side RAM. After reset that RAM is cleared by a sweep that takes one cycle per block.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset, `busy` stays high for exactly NUM_BLOCKS cycles while the directory is cleared. After that every block is uncached, so a first access to any block produces no message.
- R2: A request is taken only in a cycle where `req_valid` is high and `busy` is low. `busy` is high from the next cycle until the reply. A request presented while `busy` is high has no effect on replies, messages or directory contents.
- R3: A read miss (`req_kind` 0) to an uncached or shared block sends no message. It replies with the memory data and `reply_excl` 0, and leaves the block shared with the requester's bit added to the existing bits.
- R4: A read miss to an exclusive block sends one fetch message (`msg_kind` 1) to the owner. The owner's acknowledge data is written to memory (`mem_wr`) and returned in the reply. Afterwards the block is shared, with both the old owner and the requester present.
- R5: A write miss (`req_kind` 1) or an upgrade (`req_kind` 2) to an uncached or shared block sends an invalidate (`msg_kind` 0) to every present cache other than the requester. It replies with memory data and `reply_excl` 1, and leaves the block exclusive with only the requester present.
- R6: A write miss or upgrade to an exclusive block sends a fetch-and-invalidate (`msg_kind` 2) to the owner. It writes the returned data back to memory, returns that data with `reply_excl` 1, and leaves only the requester present.
- R7: Coherence messages go only to caches whose presence bit is set, never to the requester. They are issued one per cycle on consecutive cycles, in ascending cache index.
- R8: The reply is issued only after one acknowledge (`ack_valid`) has arrived for every message of the transaction.
- R9: The reply is a one-cycle pulse. `busy` drops in the same cycle as the reply, and a message and a reply never share a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 upgrade |
| req_src | input | CID_W | Requesting cache index |
| req_blk | input | BLK_W | Block index |
| busy | output | 1 | Controller is clearing or serving a request |
| msg_valid | output | 1 | Coherence message valid |
| msg_kind | output | 2 | 0 invalidate, 1 fetch, 2 fetch-and-invalidate |
| msg_dst | output | CID_W | Destination cache |
| ack_valid | input | 1 | Acknowledge from a targeted cache |
| ack_data | input | DATA_W | Line data carried with a fetch acknowledge |
| mem_blk | output | BLK_W | Memory block index for read and write |
| mem_rdata | input | DATA_W | Memory read data for `mem_blk` |
| mem_wr | output | 1 | Write-back strobe |
| mem_wdata | output | DATA_W | Write-back data |
| reply_valid | output | 1 | Reply to the requester |
| reply_dst | output | CID_W | Requester index |
| reply_excl | output | 1 | Requester now holds the block exclusively |
| reply_data | output | DATA_W | Block data for the requester |

## Verification
On every cycle the bound checker enforces several protocol rules. Messages appear only while busy, and they rise in index on consecutive cycles. A reply never shares a cycle with a message, always comes with the fall of busy, and only when no acknowledge is outstanding. A write-back always comes with a reply. Whether the right caches were targeted with the right message kind, whether the data came from memory or from the owner, and how the presence vector evolves across a run of requests can only be seen through the bench's scenarios. Its behavioural directory model predicts each message, write-back and reply. A request made during a busy transaction is likewise shown to be ignored only by its missing reply and by a later access that finds the block untouched.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {
    RQ_READ    = 2'd0,
    RQ_WRITE   = 2'd1,
    RQ_UPGRADE = 2'd2
  } req_kind_e;

  typedef enum logic [1:0] {
    MS_INV       = 2'd0,
    MS_FETCH     = 2'd1,
    MS_FETCH_INV = 2'd2
  } msg_kind_e;

  typedef enum logic [1:0] {
    BS_UNCACHED  = 2'd0,
    BS_SHARED    = 2'd1,
    BS_EXCLUSIVE = 2'd2
  } blk_state_e;

  typedef enum logic [2:0] {
    FS_INIT, FS_IDLE, FS_LOOKUP, FS_SEND, FS_WAIT, FS_FINISH
  } fsm_e;
endpackage

// File: rtl/dir_entry_ram.sv
module dir_entry_ram #(
  parameter int WIDTH = 6,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/dir_lowest_pick.sv
module dir_lowest_pick #(
  parameter int N = 4,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic [N-1:0]  onehot,
  output logic [IW-1:0] idx
);
  assign onehot = vec & (~vec + 1'b1);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int NUM_CACHES = 4,
  parameter int NUM_BLOCKS = 8,
  parameter int DATA_W     = 32,
  localparam int CID_W = $clog2(NUM_CACHES),
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [CID_W-1:0]  req_src,
  input  logic [BLK_W-1:0]  req_blk,
  output logic              busy,
  output logic              msg_valid,
  output logic [1:0]        msg_kind,
  output logic [CID_W-1:0]  msg_dst,
  input  logic              ack_valid,
  input  logic [DATA_W-1:0] ack_data,
  output logic [BLK_W-1:0]  mem_blk,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              reply_valid,
  output logic [CID_W-1:0]  reply_dst,
  output logic              reply_excl,
  output logic [DATA_W-1:0] reply_data
);
  localparam int N       = NUM_CACHES;
  localparam int ENTRY_W = 2 + N;
  localparam int CNT_W   = $clog2(N + 1);

  fsm_e              fsm;
  logic [BLK_W-1:0]  init_ptr;
  logic [1:0]        cur_kind;
  logic [CID_W-1:0]  cur_src;
  logic [N-1:0]      pending;
  logic [CNT_W-1:0]  exp_acks, ack_cnt;
  blk_state_e        upd_st;
  logic [N-1:0]      upd_pres;
  msg_kind_e         upd_msg;
  logic              fetching;
  logic [DATA_W-1:0] fetched;

  // directory storage
  logic               ram_we, ram_re;
  logic [BLK_W-1:0]   ram_waddr;
  logic [ENTRY_W-1:0] ram_wdata, ram_q;

  assign ram_we    = (fsm == FS_INIT) || (fsm == FS_FINISH);
  assign ram_waddr = (fsm == FS_INIT) ? init_ptr : mem_blk;
  assign ram_wdata = (fsm == FS_INIT) ? '0 : {upd_st, upd_pres};
  assign ram_re    = (fsm == FS_IDLE) && req_valid;

  dir_entry_ram #(.WIDTH(ENTRY_W), .DEPTH(NUM_BLOCKS)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .re    (ram_re),
    .raddr (req_blk),
    .rdata (ram_q)
  );

  // target selection
  logic [N-1:0]     pick_oh;
  logic [CID_W-1:0] pick_idx;

  dir_lowest_pick #(.N(N)) u_pick (
    .vec    (pending),
    .onehot (pick_oh),
    .idx    (pick_idx)
  );

  // decision on the looked-up entry
  blk_state_e   ent_st;
  logic [N-1:0] ent_pres, req_mask, others;
  blk_state_e   dec_st;
  logic [N-1:0] dec_pres, dec_tg;
  msg_kind_e    dec_msg;
  logic         dec_fetch;

  assign ent_st   = blk_state_e'(ram_q[ENTRY_W-1 -: 2]);
  assign ent_pres = ram_q[N-1:0];
  assign req_mask = {{(N-1){1'b0}}, 1'b1} << cur_src;
  assign others   = ent_pres & ~req_mask;

  always_comb begin
    dec_st    = BS_SHARED;
    dec_pres  = ent_pres | req_mask;
    dec_msg   = MS_INV;
    dec_fetch = 1'b0;
    dec_tg    = '0;
    if (cur_kind == 2'(RQ_READ)) begin
      if (ent_st == BS_EXCLUSIVE) begin
        dec_msg   = MS_FETCH;
        dec_fetch = 1'b1;
        dec_tg    = others;
      end
    end else begin
      dec_st   = BS_EXCLUSIVE;
      dec_pres = req_mask;
      dec_tg   = others;
      if (ent_st == BS_EXCLUSIVE) begin
        dec_msg   = MS_FETCH_INV;
        dec_fetch = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm         <= FS_INIT;
      init_ptr    <= '0;
      busy        <= 1'b1;
      msg_valid   <= 1'b0;
      msg_kind    <= '0;
      msg_dst     <= '0;
      mem_blk     <= '0;
      mem_wr      <= 1'b0;
      mem_wdata   <= '0;
      reply_valid <= 1'b0;
      reply_dst   <= '0;
      reply_excl  <= 1'b0;
      reply_data  <= '0;
      cur_kind    <= '0;
      cur_src     <= '0;
      pending     <= '0;
      exp_acks    <= '0;
      ack_cnt     <= '0;
      upd_st      <= BS_UNCACHED;
      upd_pres    <= '0;
      upd_msg     <= MS_INV;
      fetching    <= 1'b0;
      fetched     <= '0;
    end else begin
      msg_valid   <= 1'b0;
      reply_valid <= 1'b0;
      mem_wr      <= 1'b0;
      if (ack_valid) begin
        ack_cnt <= ack_cnt + 1'b1;
        if (fetching) fetched <= ack_data;
      end
      case (fsm)
        FS_INIT: begin
          init_ptr <= init_ptr + 1'b1;
          if (init_ptr == BLK_W'(NUM_BLOCKS - 1)) begin
            fsm  <= FS_IDLE;
            busy <= 1'b0;
          end
        end
        FS_IDLE: begin
          if (req_valid) begin
            cur_kind <= req_kind;
            cur_src  <= req_src;
            mem_blk  <= req_blk;
            busy     <= 1'b1;
            fsm      <= FS_LOOKUP;
          end
        end
        FS_LOOKUP: begin
          upd_st   <= dec_st;
          upd_pres <= dec_pres;
          upd_msg  <= dec_msg;
          fetching <= dec_fetch;
          pending  <= dec_tg;
          exp_acks <= CNT_W'($countones(dec_tg));
          ack_cnt  <= '0;
          fsm      <= (|dec_tg) ? FS_SEND : FS_FINISH;
        end
        FS_SEND: begin
          msg_valid <= 1'b1;
          msg_dst   <= pick_idx;
          msg_kind  <= upd_msg;
          pending   <= pending & ~pick_oh;
          if ((pending & ~pick_oh) == '0) fsm <= FS_WAIT;
        end
        FS_WAIT: begin
          if (ack_cnt == exp_acks) fsm <= FS_FINISH;
        end
        FS_FINISH: begin
          reply_valid <= 1'b1;
          reply_dst   <= cur_src;
          reply_excl  <= (cur_kind != 2'(RQ_READ));
          reply_data  <= fetching ? fetched : mem_rdata;
          mem_wr      <= fetching;
          mem_wdata   <= fetched;
          busy        <= 1'b0;
          fsm         <= FS_IDLE;
        end
        default: fsm <= FS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dir_home_ctrl_chk.sv
module dir_home_ctrl_chk #(
  parameter int NUM_CACHES = 4,
  localparam int CID_W = $clog2(NUM_CACHES)
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             busy,
  input logic             msg_valid,
  input logic [1:0]       msg_kind,
  input logic [CID_W-1:0] msg_dst,
  input logic             ack_valid,
  input logic             mem_wr,
  input logic             reply_valid
);
  logic [7:0] outstanding;

  always_ff @(posedge clk) begin
    if (rst) outstanding <= '0;
    else     outstanding <= outstanding + 8'(msg_valid) - 8'(ack_valid);
  end

  AST_TAKE_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> busy); // R2
  AST_MSG_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> busy); // R2
  AST_MSG_KIND_LEGAL: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> (msg_kind != 2'd3)); // R7
  AST_MSG_ASCENDING: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && $past(msg_valid)) |-> (msg_dst > $past(msg_dst))); // R7
  AST_ACKS_BEFORE_REPLY: assert property (@(posedge clk) disable iff (rst)
    reply_valid |-> (outstanding == 8'd0)); // R8
  AST_REPLY_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    reply_valid |-> $fell(busy)); // R9
  AST_NO_MSG_WITH_REPLY: assert property (@(posedge clk) disable iff (rst)
    !(msg_valid && reply_valid)); // R9
  AST_WB_WITH_REPLY: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> reply_valid); // R4
endmodule

bind dir_home_ctrl dir_home_ctrl_chk #(.NUM_CACHES(NUM_CACHES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .busy        (busy),
  .msg_valid   (msg_valid),
  .msg_kind    (msg_kind),
  .msg_dst     (msg_dst),
  .ack_valid   (ack_valid),
  .mem_wr      (mem_wr),
  .reply_valid (reply_valid)
);

// File: tb/test_dir_home_ctrl.sv
`timescale 1ns/1ps
module test_dir_home_ctrl;
  localparam int N  = 4;
  localparam int B  = 8;
  localparam int DW = 32;
  localparam int CW = $clog2(N);
  localparam int BW = $clog2(B);

  logic clk = 0, rst = 1;
  logic req_valid = 0;
  logic [1:0] req_kind = 0;
  logic [CW-1:0] req_src = 0;
  logic [BW-1:0] req_blk = 0;
  logic busy, msg_valid, mem_wr, reply_valid, reply_excl;
  logic [1:0] msg_kind;
  logic [CW-1:0] msg_dst, reply_dst;
  logic ack_valid = 0;
  logic [DW-1:0] ack_data = 0;
  logic [BW-1:0] mem_blk;
  logic [DW-1:0] mem_rdata, mem_wdata, reply_data;

  always #2.5 clk = ~clk;

  dir_home_ctrl #(.NUM_CACHES(N), .NUM_BLOCKS(B), .DATA_W(DW)) i_dir_home_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_src(req_src), .req_blk(req_blk), .busy(busy),
    .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_dst(msg_dst),
    .ack_valid(ack_valid), .ack_data(ack_data), .mem_blk(mem_blk),
    .mem_rdata(mem_rdata), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .reply_valid(reply_valid), .reply_dst(reply_dst),
    .reply_excl(reply_excl), .reply_data(reply_data)
  );

  // memory model and reference directory
  logic [DW-1:0] bmem [B];
  assign mem_rdata = bmem[mem_blk];
  int            rstate [B];   // 0 uncached, 1 shared, 2 exclusive
  logic [N-1:0]  rpres  [B];
  logic [DW-1:0] own_val [B];

  int exp_dst[$];
  int exp_kind[$];
  int checks = 0, errors = 0;
  bit rep_pending = 0, exp_wb = 0, exp_excl = 0, done = 0;
  int exp_rdst = 0, msgs_expected = 0, acks_given = 0, cur_blk = 0, vseq = 0;
  logic [DW-1:0] exp_data = 0, next_val = 0;
  string cur_tag = "R3";

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // cache responders and output monitor
  always @(negedge clk) begin
    ack_valid = 0;
    if (!rst) begin
      if (msg_valid) begin
        if (exp_dst.size() == 0) chk("R7", "unexpected message dst", msg_dst, 99);
        else begin
          chk("R7", "message dst", msg_dst, exp_dst.pop_front());
          chk(cur_tag, "message kind", msg_kind, exp_kind.pop_front());
        end
        ack_valid = 1;
        ack_data  = own_val[cur_blk];
        acks_given++;
      end
      if (mem_wr) begin
        chk("R4", "write-back data", mem_wdata, exp_data);
        bmem[mem_blk] = mem_wdata;
      end
      if (reply_valid) begin
        if (!rep_pending) chk("R2", "unexpected reply", 1, 0);
        else begin
          chk(cur_tag, "reply dst", reply_dst, exp_rdst);
          chk(cur_tag, "reply excl", reply_excl, exp_excl);
          chk(cur_tag, "reply data", reply_data, exp_data);
          chk(cur_tag, "write-back strobe", mem_wr, exp_wb);
          chk("R8", "acks before reply", acks_given, msgs_expected);
          chk("R7", "messages left", exp_dst.size(), 0);
          chk("R9", "busy at reply", busy, 0);
          if (exp_excl) own_val[cur_blk] = next_val;
          rep_pending = 0;
        end
      end
    end
  end

  task automatic do_req(int kind, int src, int blk, string tag, bit inject);
    logic [N-1:0] mask, tg;
    bit excl;
    while (busy) @(negedge clk);
    mask = N'(1) << src;
    tg   = rpres[blk] & ~mask;
    excl = (rstate[blk] == 2);
    acks_given = 0;
    msgs_expected = 0;
    if (kind != 0 || excl) begin
      for (int i = 0; i < N; i++) begin
        if (tg[i]) begin
          exp_dst.push_back(i);
          exp_kind.push_back(kind == 0 ? 1 : (excl ? 2 : 0));
          msgs_expected++;
        end
      end
    end
    exp_data = excl ? own_val[blk] : bmem[blk];
    exp_wb   = excl;
    exp_excl = (kind != 0);
    exp_rdst = src;
    cur_blk  = blk;
    cur_tag  = tag;
    vseq++;
    next_val = 32'hA000_0000 + DW'(vseq);
    if (kind == 0) begin
      rstate[blk] = 1;
      rpres[blk]  = rpres[blk] | mask;
    end else begin
      rstate[blk] = 2;
      rpres[blk]  = mask;
    end
    rep_pending = 1;
    req_valid = 1; req_kind = 2'(kind); req_src = CW'(src); req_blk = BW'(blk);
    @(negedge clk);
    req_valid = 0;
    if (inject) begin
      chk("R2", "busy after accept", busy, 1);
      req_valid = 1; req_kind = 2'd1; req_src = CW'(3); req_blk = BW'(6);
      @(negedge clk);
      req_valid = 0;
    end
    while (rep_pending) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    logic [15:0] lfsr;
    for (int i = 0; i < B; i++) begin
      bmem[i] = 32'h1000_0000 + DW'(i * 17);
      rstate[i] = 0; rpres[i] = '0; own_val[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1", "busy right after reset", busy, 1);
    chk("R1", "no reply after reset", reply_valid, 0);
    chk("R1", "no message after reset", msg_valid, 0);
    n = 0;
    while (busy) begin @(negedge clk); n++; end
    chk("R1", "clear sweep length", n, B);

    do_req(0, 0, 0, "R3", 0);   // uncached read
    do_req(0, 2, 0, "R3", 0);   // shared read
    do_req(0, 3, 0, "R3", 0);
    do_req(2, 2, 0, "R5", 0);   // upgrade, invalidates 0 and 3
    do_req(0, 1, 0, "R4", 0);   // fetch from owner 2
    do_req(1, 3, 0, "R5", 0);   // write miss over sharers 1,2
    do_req(1, 0, 0, "R6", 0);   // fetch-invalidate owner 3
    do_req(0, 1, 5, "R3", 1);   // with a request injected while busy
    repeat (6) @(negedge clk);
    chk("R2", "no reply for ignored request", reply_valid, 0);
    do_req(0, 0, 6, "R2", 0);   // block 6 must still be uncached
    do_req(1, 1, 5, "R5", 0);   // sole sharer writes: no messages
    for (int c = 0; c < N; c++) do_req(0, c, 7, "R3", 0);
    do_req(1, 1, 7, "R5", 0);   // invalidates 0, 2, 3 in order

    lfsr = 16'hACE1;
    for (int k = 0; k < 60; k++) begin
      int kd, sr, bk;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      kd = int'(lfsr[1:0]) % 3;
      sr = int'(lfsr[3:2]);
      bk = int'(lfsr[6:4]);
      if (rstate[bk] == 2 && rpres[bk] == (N'(1) << sr)) sr = (sr + 1) % N;
      do_req(kd, sr, bk, (rstate[bk] == 2) ? (kd == 0 ? "R4" : "R6")
                                           : (kd == 0 ? "R3" : "R5"), 0);
    end
    repeat (4) @(negedge clk);
    chk("R7", "leftover expected messages", exp_dst.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule